// File: doc/BRIEF.md
# Multi-Bank IN Endpoint Packet Buffer

This block holds outgoing packets for one device-to-host endpoint. A CPU or DMA engine loads bytes one at a time into the bank that is being filled. A bank becomes a queued packet in one of two ways. Software can raise a packet-ready strobe. Or, in auto-validate mode, the hardware queues the bank when its last byte location is written. Auto-validate mode lets software stream several full packets through the banks and take only one interrupt per burst. Each bank records its own length, so short packets and zero-length packets pass to the reader with their exact size.

The host-side reader drains queued packets as a valid/ready byte stream. Beat rules: once `rd_valid` is high, `rd_data`, `rd_last` and `rd_zlp` stay constant until a beat is taken with `rd_ready` high. The reader may hold `rd_ready` low for as long as it likes, and that back-pressure does not affect the write side. A zero-length packet appears as one beat with `rd_zlp` and `rd_last` both high, and its data carries no meaning.

The write side is a plain strobe port with no back-pressure. Software looks at `wr_space` or `busy_cnt` before it writes. Two interrupt lines, one for "room for a packet" and one for "all banks drained", are level outputs. Each is gated by an enable bit that has its own set and clear strobes. `cfg_auto` and `cfg_iso` may change only while no bank is busy and the current bank holds no bytes.

Top module: `ep_in_bankbuf`

## Requirements
- R1: `busy_cnt` equals the number of queued banks that are not yet fully read. `wr_space` is 1 exactly when `busy_cnt` is below the number of usable banks (NUM_BANKS normally, 1 in isochronous mode).
- R2: With `cfg_auto`=1 and `cfg_iso`=0, an accepted write to the last byte position of a bank queues that bank with length BANK_BYTES and moves filling to the next bank. `busy_cnt` rises by one in the cycle after the write.
- R3: A `pkt_rdy` strobe while `wr_space`=1 queues the current bank with a length equal to the bytes written into it, so short packets are kept. If auto-validate is off, a write into a bank that already holds BANK_BYTES bytes is dropped and sets `ovf_err`.
- R4: `irq_txrdy` is high when its enable bit is set and `wr_space`=1. The enable bit is set by `txrdy_ie_set` and cleared by `txrdy_ie_clr`. Clear wins when both strobes come together, and the bit is cleared at reset.
- R5: `irq_allfree` is high when its enable bit is set and `busy_cnt`=0. The enable bit is set by `allfree_ie_set` and cleared by `allfree_ie_clr`. Clear wins when both strobes come together, and the bit is cleared at reset.
- R6: A `pkt_rdy` strobe with no bytes written queues a zero-length packet. The reader sees it as one beat with `rd_zlp`=1 and `rd_last`=1.
- R7: With `cfg_iso`=1, only one bank is used, auto-validate has no effect, and `busy_cnt` never exceeds 1.
- R8: Banks are filled in strict round-robin order. Packets are delivered to the reader in the order they were queued, and each packet's bytes come out in the order they were written.
- R9: `rd_valid` is 1 while `busy_cnt` is above 0. Held beats stay stable under back-pressure. `rd_last` marks the final byte of a packet, and the handshake on that beat frees the bank, so `busy_cnt` drops in the next cycle.
- R10: A write or `pkt_rdy` strobe while `wr_space`=0 is ignored and sets `ovf_err`. `ovf_err` stays set until reset.
- R11: After reset, `busy_cnt`=0, `rd_valid`=0, `ovf_err`=0, `wr_space`=1 and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_auto | input | 1 | Auto-validate mode |
| cfg_iso | input | 1 | Isochronous endpoint: single bank, no auto-validate |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | DW | Byte to write |
| pkt_rdy | input | 1 | Software packet-ready strobe |
| wr_space | output | 1 | A bank is free for writing |
| busy_cnt | output | CW | Number of queued, undrained banks |
| ovf_err | output | 1 | Sticky write-overflow error |
| rd_valid | output | 1 | Read beat valid |
| rd_ready | input | 1 | Reader accepts beat |
| rd_data | output | DW | Read byte |
| rd_last | output | 1 | Final beat of the packet |
| rd_zlp | output | 1 | Beat stands for a zero-length packet |
| txrdy_ie_set | input | 1 | Enable the room-for-packet interrupt |
| txrdy_ie_clr | input | 1 | Disable the room-for-packet interrupt |
| allfree_ie_set | input | 1 | Enable the all-free interrupt |
| allfree_ie_clr | input | 1 | Disable the all-free interrupt |
| irq_txrdy | output | 1 | Room-for-packet interrupt |
| irq_allfree | output | 1 | All-banks-free interrupt |

## Verification
Wrong internal state shows up at the ports within one cycle. A wrong busy count moves `wr_space`, `rd_valid` and both interrupts at once. A wrong pointer or stored length shows on the next read beat as a wrong byte, or as `rd_last` in the wrong place. A fill counter that does not return to zero pushes every later auto-validate point, so `busy_cnt` rises too early or too late when a bank is filled. Reading back whole packets in order therefore checks the internal counters as well as the data.

// File: rtl/ep_in_pkg.sv
package ep_in_pkg;
  localparam int MAX_BANKS = 3;

  // next state of an interrupt enable bit: clear dominates set
  function automatic logic ie_next(input logic cur, input logic set_s, input logic clr_s);
    if (clr_s) return 1'b0;
    if (set_s) return 1'b1;
    return cur;
  endfunction
endpackage

// File: rtl/ep_in_bank_mem.sv
module ep_in_bank_mem #(
  parameter int NB = 2,
  parameter int BB = 8,
  parameter int DW = 8,
  parameter int AW = 3,
  parameter int LW = 4,
  parameter int PW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] wbank,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          len_we,
  input  logic [PW-1:0] len_bank,
  input  logic [LW-1:0] len_val,
  input  logic [PW-1:0] rbank,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] rlen
);
  logic [DW-1:0] bank_rd  [NB];
  logic [LW-1:0] bank_len [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DW-1:0] store [BB];
    logic [LW-1:0] len_q;

    always_ff @(posedge clk) begin
      if (we && (wbank == PW'(b))) store[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                            len_q <= '0;
      else if (len_we && (len_bank == PW'(b))) len_q <= len_val;
    end

    assign bank_rd[b]  = store[raddr];
    assign bank_len[b] = len_q;
  end

  assign rdata = bank_rd[rbank];
  assign rlen  = bank_len[rbank];
endmodule

// File: rtl/ep_in_bank_track.sv
module ep_in_bank_track #(
  parameter int NB = 2,
  parameter int PW = 1,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          single,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] wbank,
  output logic [PW-1:0] rbank,
  output logic [CW-1:0] busy,
  output logic          space
);
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] busy_q;
  logic [CW-1:0] usable;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(NB - 1)) ? '0 : p + PW'(1);
  endfunction

  assign usable = single ? CW'(1) : CW'(NB);
  assign space  = busy_q < usable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      busy_q <= '0;
    end else begin
      if (push && !single) wp_q <= step(wp_q);
      if (pop  && !single) rp_q <= step(rp_q);
      case ({push, pop})
        2'b10:   busy_q <= busy_q + CW'(1);
        2'b01:   busy_q <= busy_q - CW'(1);
        default: busy_q <= busy_q;
      endcase
    end
  end

  assign wbank = single ? '0 : wp_q;
  assign rbank = single ? '0 : rp_q;
  assign busy  = busy_q;
endmodule

// File: rtl/ep_in_irq_ctl.sv
module ep_in_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic txrdy_set,
  input  logic txrdy_clr,
  input  logic allfree_set,
  input  logic allfree_clr,
  input  logic have_space,
  input  logic all_free,
  output logic irq_txrdy,
  output logic irq_allfree
);
  import ep_in_pkg::*;

  logic txrdy_en_q, allfree_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txrdy_en_q   <= 1'b0;
      allfree_en_q <= 1'b0;
    end else begin
      txrdy_en_q   <= ie_next(txrdy_en_q, txrdy_set, txrdy_clr);
      allfree_en_q <= ie_next(allfree_en_q, allfree_set, allfree_clr);
    end
  end

  assign irq_txrdy   = txrdy_en_q && have_space;
  assign irq_allfree = allfree_en_q && all_free;
endmodule

// File: rtl/ep_in_bankbuf.sv
module ep_in_bankbuf #(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_BYTES = 64,
  parameter int DW         = 8,
  localparam int CW = $clog2(NUM_BANKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_auto,
  input  logic          cfg_iso,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          pkt_rdy,
  output logic          wr_space,
  output logic [CW-1:0] busy_cnt,
  output logic          ovf_err,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  output logic          rd_zlp,
  input  logic          txrdy_ie_set,
  input  logic          txrdy_ie_clr,
  input  logic          allfree_ie_set,
  input  logic          allfree_ie_clr,
  output logic          irq_txrdy,
  output logic          irq_allfree
);
  localparam int AW = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1;
  localparam int LW = $clog2(BANK_BYTES + 1);
  localparam int PW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam logic [LW-1:0] FULL_LEN = LW'(BANK_BYTES);
  localparam logic [LW-1:0] LAST_POS = LW'(BANK_BYTES - 1);

  logic [LW-1:0] fill_q;
  logic [LW-1:0] rd_idx_q;
  logic          ovf_q;
  logic          auto_on;
  logic          accept;
  logic          auto_hit;
  logic          push;
  logic          pop;
  logic          beat;
  logic [LW-1:0] push_len;
  logic [PW-1:0] wbank, rbank;
  logic [LW-1:0] rlen;
  logic          space;
  logic [CW-1:0] busy;

  // write side
  assign auto_on  = cfg_auto && !cfg_iso;
  assign accept   = wr_en && space && (fill_q < FULL_LEN);
  assign auto_hit = auto_on && accept && (fill_q == LAST_POS);
  assign push     = space && (auto_hit || pkt_rdy);
  assign push_len = fill_q + LW'(accept);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (push)        fill_q <= '0;
      else if (accept) fill_q <= fill_q + LW'(1);
      if ((wr_en && !accept) || (pkt_rdy && !space)) ovf_q <= 1'b1;
    end
  end

  // read side
  assign rd_valid = (busy != '0);
  assign rd_zlp   = (rlen == '0);
  assign rd_last  = rd_zlp || (rd_idx_q == rlen - LW'(1));
  assign beat     = rd_valid && rd_ready;
  assign pop      = beat && rd_last;

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_idx_q <= '0;
    else if (pop)     rd_idx_q <= '0;
    else if (beat)    rd_idx_q <= rd_idx_q + LW'(1);
  end

  ep_in_bank_track #(.NB(NUM_BANKS), .PW(PW), .CW(CW)) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .single (cfg_iso),
    .push   (push),
    .pop    (pop),
    .wbank  (wbank),
    .rbank  (rbank),
    .busy   (busy),
    .space  (space)
  );

  ep_in_bank_mem #(
    .NB(NUM_BANKS), .BB(BANK_BYTES), .DW(DW), .AW(AW), .LW(LW), .PW(PW)
  ) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (accept),
    .wbank    (wbank),
    .waddr    (fill_q[AW-1:0]),
    .wdata    (wr_data),
    .len_we   (push),
    .len_bank (wbank),
    .len_val  (push_len),
    .rbank    (rbank),
    .raddr    (rd_idx_q[AW-1:0]),
    .rdata    (rd_data),
    .rlen     (rlen)
  );

  ep_in_irq_ctl u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .txrdy_set   (txrdy_ie_set),
    .txrdy_clr   (txrdy_ie_clr),
    .allfree_set (allfree_ie_set),
    .allfree_clr (allfree_ie_clr),
    .have_space  (space),
    .all_free    (busy == '0),
    .irq_txrdy   (irq_txrdy),
    .irq_allfree (irq_allfree)
  );

  assign wr_space = space;
  assign busy_cnt = busy;
  assign ovf_err  = ovf_q;
endmodule

// File: rtl/ep_in_bankbuf_chk.sv
module ep_in_bankbuf_chk #(
  parameter int NUM_BANKS = 2,
  parameter int DW        = 8,
  localparam int CW = $clog2(NUM_BANKS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_iso,
  input logic          wr_en,
  input logic          pkt_rdy,
  input logic          wr_space,
  input logic [CW-1:0] busy_cnt,
  input logic          ovf_err,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data,
  input logic          rd_last,
  input logic          rd_zlp,
  input logic          irq_txrdy,
  input logic          irq_allfree
);
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CW'(NUM_BANKS)); // R1

  AST_PUSH_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_rdy && wr_space && !(rd_valid && rd_ready && rd_last))
    |=> (busy_cnt == $past(busy_cnt) + CW'(1))); // R3

  AST_TXRDY_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    irq_txrdy |-> wr_space); // R4

  AST_ALLFREE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_allfree |-> (busy_cnt == '0)); // R5

  AST_ZLP_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_zlp) |-> rd_last); // R6

  AST_ISO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_iso && busy_cnt <= CW'(1)) |=> (!cfg_iso || busy_cnt <= CW'(1))); // R7

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last) && $stable(rd_zlp))); // R9

  AST_OVF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_space) |=> ovf_err); // R10

  AST_OVF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_rdy && !wr_space) |=> ovf_err); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err); // R10
endmodule

bind ep_in_bankbuf ep_in_bankbuf_chk #(.NUM_BANKS(NUM_BANKS), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_iso     (cfg_iso),
  .wr_en       (wr_en),
  .pkt_rdy     (pkt_rdy),
  .wr_space    (wr_space),
  .busy_cnt    (busy_cnt),
  .ovf_err     (ovf_err),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .rd_data     (rd_data),
  .rd_last     (rd_last),
  .rd_zlp      (rd_zlp),
  .irq_txrdy   (irq_txrdy),
  .irq_allfree (irq_allfree)
);

// File: tb/sim_ep_in_bankbuf.sv
`timescale 1ns/1ps
module sim_ep_in_bankbuf;
  localparam int NB = 3;
  localparam int BB = 4;
  localparam int CW = $clog2(NB + 1);

  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_PR = 2'd1;
  localparam logic [1:0] OP_RD = 2'd2;
  localparam logic [1:0] OP_BZ = 2'd3;
  localparam int NV = 17;
  // {op, arg byte, expected}: WR/PR/BZ expected = busy_cnt, RD expected = {last, zlp}
  localparam logic [13:0] VEC [NV] = '{
    {OP_WR, 8'h11, 4'd0}, {OP_WR, 8'h12, 4'd0}, {OP_WR, 8'h13, 4'd0},
    {OP_WR, 8'h14, 4'd1}, {OP_WR, 8'h21, 4'd1}, {OP_WR, 8'h22, 4'd1},
    {OP_PR, 8'h00, 4'd2}, {OP_PR, 8'h00, 4'd3},
    {OP_RD, 8'h11, 4'd0}, {OP_RD, 8'h12, 4'd0}, {OP_RD, 8'h13, 4'd0},
    {OP_RD, 8'h14, 4'd2}, {OP_BZ, 8'h00, 4'd2},
    {OP_RD, 8'h21, 4'd0}, {OP_RD, 8'h22, 4'd2},
    {OP_RD, 8'h00, 4'd3}, {OP_BZ, 8'h00, 4'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_auto = 1'b0, cfg_iso = 1'b0;
  logic wr_en = 1'b0, pkt_rdy = 1'b0, rd_ready = 1'b0;
  logic [7:0] wr_data = '0;
  logic txrdy_ie_set = 1'b0, txrdy_ie_clr = 1'b0;
  logic allfree_ie_set = 1'b0, allfree_ie_clr = 1'b0;
  logic wr_space, ovf_err, rd_valid, rd_last, rd_zlp, irq_txrdy, irq_allfree;
  logic [CW-1:0] busy_cnt;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ep_in_bankbuf #(.NUM_BANKS(NB), .BANK_BYTES(BB), .DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_auto(cfg_auto), .cfg_iso(cfg_iso),
    .wr_en(wr_en), .wr_data(wr_data), .pkt_rdy(pkt_rdy), .wr_space(wr_space),
    .busy_cnt(busy_cnt), .ovf_err(ovf_err), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_last(rd_last), .rd_zlp(rd_zlp),
    .txrdy_ie_set(txrdy_ie_set), .txrdy_ie_clr(txrdy_ie_clr),
    .allfree_ie_set(allfree_ie_set), .allfree_ie_clr(allfree_ie_clr),
    .irq_txrdy(irq_txrdy), .irq_allfree(irq_allfree)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic strobe_pr();
    @(negedge clk); pkt_rdy = 1'b1;
    @(negedge clk); pkt_rdy = 1'b0;
  endtask

  // checks the held beat at a negedge, then takes it
  task automatic rd_beat(input string tag, input logic [7:0] d, input logic last, input logic zlp);
    @(negedge clk);
    chk({tag, " rd_valid"}, int'(rd_valid), 1);
    if (!zlp) chk({tag, " rd_data"}, int'(rd_data), int'(d));
    chk({tag, " rd_last"}, int'(rd_last), int'(last));
    chk({tag, " rd_zlp"}, int'(rd_zlp), int'(zlp));
    rd_ready = 1'b1;
    @(negedge clk); rd_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R9: actual hung expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R11 reset state
    chk("R11 busy_cnt", int'(busy_cnt), 0);
    chk("R11 rd_valid", int'(rd_valid), 0);
    chk("R11 ovf_err", int'(ovf_err), 0);
    chk("R11 wr_space", int'(wr_space), 1);
    chk("R11 irq_txrdy", int'(irq_txrdy), 0);
    chk("R11 irq_allfree", int'(irq_allfree), 0);

    // vector table, auto-validate on
    cfg_auto = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [7:0] arg;
      logic [3:0] ex;
      {op, arg, ex} = VEC[i];
      case (op)
        OP_WR: begin wr_byte(arg); chk($sformatf("R2 vec%0d busy", i), int'(busy_cnt), int'(ex)); end
        OP_PR: begin strobe_pr(); chk($sformatf("R3 vec%0d busy", i), int'(busy_cnt), int'(ex)); end
        OP_RD: rd_beat(ex[0] ? $sformatf("R6 vec%0d", i) : $sformatf("R8 vec%0d", i), arg, ex[1], ex[0]);
        default: begin @(negedge clk); chk($sformatf("R9 vec%0d busy", i), int'(busy_cnt), int'(ex)); end
      endcase
    end

    // R4 R5: interrupt enables, full buffer, overflow
    @(negedge clk); txrdy_ie_set = 1'b1; allfree_ie_set = 1'b1;
    @(negedge clk); txrdy_ie_set = 1'b0; allfree_ie_set = 1'b0;
    chk("R4 irq_txrdy enabled", int'(irq_txrdy), 1);
    chk("R5 irq_allfree enabled", int'(irq_allfree), 1);
    for (int k = 0; k < NB * BB; k++) wr_byte(8'h40 + 8'(k));
    chk("R1 busy full", int'(busy_cnt), NB);
    chk("R1 wr_space full", int'(wr_space), 0);
    chk("R4 irq_txrdy full", int'(irq_txrdy), 0);
    chk("R5 irq_allfree busy", int'(irq_allfree), 0);
    chk("R10 ovf before", int'(ovf_err), 0);
    wr_byte(8'hEE);
    chk("R10 ovf after write", int'(ovf_err), 1);
    chk("R10 busy unchanged", int'(busy_cnt), NB);
    strobe_pr();
    chk("R10 busy after strobe", int'(busy_cnt), NB);
    for (int k = 0; k < NB * BB; k++)
      rd_beat("R8 drain", 8'h40 + 8'(k), (k % BB) == BB - 1, 1'b0);
    chk("R5 irq_allfree drained", int'(irq_allfree), 1);
    chk("R4 irq_txrdy drained", int'(irq_txrdy), 1);
    chk("R10 ovf sticky", int'(ovf_err), 1);
    @(negedge clk); txrdy_ie_set = 1'b1; txrdy_ie_clr = 1'b1; allfree_ie_clr = 1'b1;
    @(negedge clk); txrdy_ie_set = 1'b0; txrdy_ie_clr = 1'b0; allfree_ie_clr = 1'b0;
    chk("R4 clear wins", int'(irq_txrdy), 0);
    chk("R5 cleared", int'(irq_allfree), 0);

    // R7 isochronous: one bank, no auto-validate
    do_reset();
    chk("R11 ovf after reset", int'(ovf_err), 0);
    cfg_iso = 1'b1;
    for (int k = 0; k < BB; k++) wr_byte(8'h60 + 8'(k));
    chk("R7 no auto validate", int'(busy_cnt), 0);
    strobe_pr();
    chk("R7 busy one", int'(busy_cnt), 1);
    chk("R7 no space", int'(wr_space), 0);
    for (int k = 0; k < BB; k++) rd_beat("R7 read", 8'h60 + 8'(k), k == BB - 1, 1'b0);
    chk("R7 busy drained", int'(busy_cnt), 0);

    // R3 manual mode overfill
    do_reset();
    cfg_iso = 1'b0; cfg_auto = 1'b0;
    for (int k = 0; k < BB + 1; k++) wr_byte(8'h70 + 8'(k));
    chk("R3 manual no validate", int'(busy_cnt), 0);
    chk("R3 overfill ovf", int'(ovf_err), 1);
    strobe_pr();
    chk("R3 manual busy", int'(busy_cnt), 1);
    for (int k = 0; k < BB; k++) rd_beat("R3 read", 8'h70 + 8'(k), k == BB - 1, 1'b0);
    @(negedge clk);
    chk("R9 rd_valid drained", int'(rd_valid), 0);

    finish_run();
  end
endmodule